// File: doc/BRIEF.md
# In-Memory Compare-Exchange Sorter

The block sorts a fixed array of signed words into ascending order. The array lives in a single-port synchronous RAM inside the block. At reset the RAM is loaded from a constant table that is computed from a seed parameter. A software-style nested sweep then orders the array in place.

An outer index selects one entry of the array, and a slot timer gives each outer index a fixed window of enabled cycles. Inside that window an inner index walks over every entry above the outer index. For each pair the block spends four cycles on the one RAM port: it fetches the upper word, captures both words, writes the larger word to the upper address and then writes the smaller word to the lower address. When a window ends, its lower entry holds the minimum of everything from that entry upward.

A single enable input pauses the whole block, RAM port included. The data output always shows the RAM read port. A done flag rises after the last window.

Top module: `bubble_sorter`

## Requirements
- R1: While rst_ni is low, and before the first enabled cycle after reset, data_o is 0 and done_o is 0.
- R2: Reset loads entry k with the signed value ((k*11 + TABLE_SEED) mod 29)*7919 - 100000. The first two enabled cycles after reset place entry 0 and then entry 1 of that table on data_o.
- R3: Each outer index owns OUTER_PERIOD enabled cycles. The outer index stops once it reaches DEPTH-1. done_o goes high on the second clock edge after that, at any init_i level, and stays high until reset.
- R4: Each compare-exchange uses four enabled cycles in this order: fetch the upper word, capture the upper word, write the signed maximum to the upper address, write the signed minimum to the lower address. After the fourth and fifth enabled cycles from reset, data_o shows max(entry0, entry1) and then min(entry0, entry1).
- R5: data_o follows the address of the previous enabled cycle with one cycle of latency. A write in that cycle is returned on data_o as the new value. After the third enabled cycle, data_o shows entry 0 again.
- R6: While init_i is low, no counter, RAM word or data_o changes.
- R7: At the first cycle of window k (enabled-cycle count k*OUTER_PERIOD, for k from 1 to DEPTH-1), data_o shows the final sorted entry k-1. One enabled cycle after the last window starts, data_o shows the final entry DEPTH-1.
- R8: The final array is non-decreasing under signed comparison and is a permutation of the reset table, with duplicate values kept.
- R9: A reset in the middle of a sort reloads the table, clears the counters and done_o, and a later full run sorts the array again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, reloads the table |
| init_i | input | 1 | Run enable; low pauses the block |
| data_o | output | DATA_W | RAM read data |
| done_o | output | 1 | Sort finished |

## Verification
The bench builds two instances. The default one has 32 entries of 32 bits and a 125-cycle window, so the last compare-exchange of the first window lands exactly on the window's final cycle. The second has 8 entries of 20 bits and a 33-cycle window, which leaves idle cycles at the end of each window and tests sign handling below 32 bits. Both share random pauses on init, which shift the sweep schedule against the clock, and the observation points of R7 together rebuild the whole sorted array.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

  typedef enum logic [1:0] {
    PH_CAP_LO  = 2'd0,  // capture lower word, fetch upper
    PH_CAP_HI  = 2'd1,  // capture upper word
    PH_PUT_MAX = 2'd2,  // write larger word to upper address
    PH_PUT_MIN = 2'd3   // write smaller word to lower address
  } phase_e;

  function automatic int seed_word(input int idx, input int seed);
    return ((idx * 11 + seed) % 29) * 7919 - 100000;
  endfunction

endpackage

// File: rtl/bsort_ram.sv
module bsort_ram #(
  parameter int DEPTH      = 32,
  parameter int DATA_W     = 32,
  parameter int TABLE_SEED = 29,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) begin
        mem_q[k] <= DATA_W'(bsort_pkg::seed_word(k, TABLE_SEED));
      end
      rdata_q <= '0;
    end else if (en_i) begin
      if (we_i) begin
        mem_q[addr_i] <= wdata_i;
        rdata_q       <= wdata_i;  // write-first
      end else begin
        rdata_q <= mem_q[addr_i];
      end
    end
  end

  assign rdata_o = rdata_q;

  p_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(rdata_q));

  p_write_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && we_i |=> rdata_q == $past(wdata_i));

endmodule

// File: rtl/bsort_ctrl.sv
module bsort_ctrl
  import bsort_pkg::*;
#(
  parameter int DEPTH        = 32,
  parameter int OUTER_PERIOD = 125,
  localparam int ADDR_W      = $clog2(DEPTH),
  localparam int IDX_W       = $clog2(DEPTH) + 1,
  localparam int TMR_W       = $clog2(OUTER_PERIOD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic              sel_max_o,
  output logic              cap_lo_o,
  output logic              cap_hi_o,
  output logic              done_o
);

  logic [IDX_W-1:0] i_q, j_q;
  logic [TMR_W-1:0] tmr_q;
  phase_e           ph_q;
  logic             fin_d_q, done_q;
  logic             fin, lead, win_end, j_live, op_act;

  assign fin     = (i_q == IDX_W'(DEPTH - 1));
  assign lead    = (tmr_q == '0);
  assign win_end = (tmr_q == TMR_W'(OUTER_PERIOD - 1));
  assign j_live  = (j_q < IDX_W'(DEPTH));
  assign op_act  = en_i && !fin && !lead && j_live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_q   <= '0;
      j_q   <= IDX_W'(1);
      tmr_q <= '0;
      ph_q  <= PH_CAP_LO;
    end else if (en_i && !fin) begin
      if (win_end) begin
        tmr_q <= '0;
        i_q   <= i_q + IDX_W'(1);
        j_q   <= i_q + IDX_W'(2);
        ph_q  <= PH_CAP_LO;
      end else begin
        tmr_q <= tmr_q + TMR_W'(1);
        if (op_act) begin
          ph_q <= phase_e'(ph_q + 2'd1);
          if (ph_q == PH_PUT_MIN) j_q <= j_q + IDX_W'(1);
        end
      end
    end
  end

  // completion delay runs on the raw clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fin_d_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      fin_d_q <= fin;
      done_q  <= fin_d_q;
    end
  end

  assign addr_o    = (op_act && (ph_q == PH_CAP_LO || ph_q == PH_PUT_MAX))
                     ? j_q[ADDR_W-1:0] : i_q[ADDR_W-1:0];
  assign we_o      = op_act && (ph_q == PH_PUT_MAX || ph_q == PH_PUT_MIN);
  assign sel_max_o = (ph_q == PH_PUT_MAX);
  assign cap_lo_o  = op_act && (ph_q == PH_CAP_LO);
  assign cap_hi_o  = op_act && (ph_q == PH_CAP_HI);
  assign done_o    = done_q;

  p_pair_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_act |-> j_q > i_q);

  p_window_fit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !fin && lead |-> ph_q == PH_CAP_LO);

  p_done_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);

  p_done_lag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fin) |-> ##2 done_q);

endmodule

// File: rtl/bsort_cswap.sv
module bsort_cswap #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_lo_i,
  input  logic              cap_hi_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] max_o,
  output logic [DATA_W-1:0] min_o
);

  logic signed [DATA_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cap_lo_i) lo_q <= rdata_i;
      if (cap_hi_i) hi_q <= rdata_i;
    end
  end

  assign max_o = (hi_q > lo_q) ? hi_q : lo_q;
  assign min_o = (lo_q < hi_q) ? lo_q : hi_q;

endmodule

// File: rtl/bubble_sorter.sv
module bubble_sorter #(
  parameter int DEPTH        = 32,
  parameter int DATA_W       = 32,
  parameter int OUTER_PERIOD = 125,
  parameter int TABLE_SEED   = 29,
  localparam int ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);

  logic [ADDR_W-1:0] addr;
  logic              we, sel_max, cap_lo, cap_hi;
  logic [DATA_W-1:0] rdata, max_w, min_w, wdata;

  bsort_ctrl #(
    .DEPTH       (DEPTH),
    .OUTER_PERIOD(OUTER_PERIOD)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (init_i),
    .addr_o   (addr),
    .we_o     (we),
    .sel_max_o(sel_max),
    .cap_lo_o (cap_lo),
    .cap_hi_o (cap_hi),
    .done_o   (done_o)
  );

  bsort_cswap #(.DATA_W(DATA_W)) u_cswap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_lo_i(cap_lo),
    .cap_hi_i(cap_hi),
    .rdata_i (rdata),
    .max_o   (max_w),
    .min_o   (min_w)
  );

  assign wdata = sel_max ? max_w : min_w;

  bsort_ram #(
    .DEPTH     (DEPTH),
    .DATA_W    (DATA_W),
    .TABLE_SEED(TABLE_SEED)
  ) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (init_i),
    .we_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata)
  );

  assign data_o = rdata;

endmodule

// File: tb/bubble_sorter_tb.sv
module bubble_sorter_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int D_BIG = 32, P_BIG = 125, S_BIG = 29;
  localparam int D_SM  = 8,  P_SM  = 33,  S_SM  = 5;
  localparam int F_BIG = (D_BIG - 1) * P_BIG;
  localparam int F_SM  = (D_SM - 1) * P_SM;

  logic        clk = 1'b0, rst_ni = 1'b0, init_i = 1'b0;
  logic [31:0] dat_big;
  logic [19:0] dat_sm;
  logic        done_big, done_sm;

  always #2.5 clk = ~clk;

  bubble_sorter #(.DEPTH(D_BIG), .DATA_W(32), .OUTER_PERIOD(P_BIG), .TABLE_SEED(S_BIG)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .init_i(init_i), .data_o(dat_big), .done_o(done_big));

  bubble_sorter #(.DEPTH(D_SM), .DATA_W(20), .OUTER_PERIOD(P_SM), .TABLE_SEED(S_SM)) u_dut_small (
    .clk_i(clk), .rst_ni(rst_ni), .init_i(init_i), .data_o(dat_sm), .done_o(done_sm));

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  int unsigned e_cnt;
  bit fin_b, fin_s;
  int pf_b, pf_s, prev_b, prev_s;
  int got_big[D_BIG];
  int got_sm[D_SM];

  function automatic int tbl(input int k, input int s);
    return ((k * 11 + s) % 29) * 7919 - 100000;
  endfunction

  function automatic int cur_big();
    return $signed(dat_big);
  endfunction

  function automatic int cur_sm();
    int v;
    v = $signed(dat_sm);
    return v;
  endfunction

  function automatic int sorted_at(input int n, input int s, input int pos);
    int a[32];
    for (int k = 0; k < n; k++) a[k] = tbl(k, s);
    for (int k = 1; k < n; k++) begin
      int key = a[k];
      int m = k - 1;
      while (m >= 0 && a[m] > key) begin
        a[m + 1] = a[m];
        m--;
      end
      a[m + 1] = key;
    end
    return a[pos];
  endfunction

  task automatic chk_eq(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic observe(input bit en);
    int cb, cs;
    cb = cur_big();
    cs = cur_sm();
    if (!en) begin
      chk_eq("R6 pause holds data big", cb, prev_b);
      chk_eq("R6 pause holds data small", cs, prev_s);
    end else begin
      if (e_cnt % P_BIG == 0 && e_cnt / P_BIG >= 1 && e_cnt / P_BIG <= D_BIG - 1)
        got_big[e_cnt / P_BIG - 1] = cb;
      if (e_cnt == F_BIG + 1) got_big[D_BIG - 1] = cb;
      if (e_cnt % P_SM == 0 && e_cnt / P_SM >= 1 && e_cnt / P_SM <= D_SM - 1)
        got_sm[e_cnt / P_SM - 1] = cs;
      if (e_cnt == F_SM + 1) got_sm[D_SM - 1] = cs;
    end
    if (fin_b ? (pf_b <= 3) : (en && e_cnt % 250 == 0))
      chk_eq("R3 done big", int'(done_big), int'(fin_b && pf_b >= 2));
    if (fin_s ? (pf_s <= 3) : (en && e_cnt % 50 == 0))
      chk_eq("R3 done small", int'(done_sm), int'(fin_s && pf_s >= 2));
    prev_b = cb;
    prev_s = cs;
  endtask

  task automatic tick(input bit en);
    init_i = en;
    @(posedge clk);
    if (en) e_cnt++;
    if (fin_b) pf_b++;
    else if (en && e_cnt == F_BIG) begin fin_b = 1; pf_b = 0; end
    if (fin_s) pf_s++;
    else if (en && e_cnt == F_SM) begin fin_s = 1; pf_s = 0; end
    @(negedge clk);
    observe(en);
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    init_i = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq({req, " data big in reset"}, cur_big(), 0);
    chk_eq({req, " data small in reset"}, cur_sm(), 0);
    chk_eq({req, " done big in reset"}, int'(done_big), 0);
    chk_eq({req, " done small in reset"}, int'(done_sm), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_eq({req, " data big after release"}, cur_big(), 0);
    chk_eq({req, " done small after release"}, int'(done_sm), 0);
    e_cnt = 0; fin_b = 0; fin_s = 0; pf_b = 0; pf_s = 0;
    prev_b = 0; prev_s = 0;
  endtask

  task automatic first_steps(input string tag);
    int b0, b1, s0, s1;
    b0 = tbl(0, S_BIG); b1 = tbl(1, S_BIG);
    s0 = tbl(0, S_SM);  s1 = tbl(1, S_SM);
    tick(1'b1);
    chk_eq({tag, " R2 entry0 big"}, cur_big(), b0);
    chk_eq({tag, " R2 entry0 small"}, cur_sm(), s0);
    tick(1'b1);
    chk_eq({tag, " R2 entry1 big"}, cur_big(), b1);
    chk_eq({tag, " R2 entry1 small"}, cur_sm(), s1);
    tick(1'b1);
    chk_eq({tag, " R5 reread lower big"}, cur_big(), b0);
    chk_eq({tag, " R5 reread lower small"}, cur_sm(), s0);
    tick(1'b1);
    chk_eq({tag, " R4 max written big"}, cur_big(), (b1 > b0) ? b1 : b0);
    chk_eq({tag, " R4 max written small"}, cur_sm(), (s1 > s0) ? s1 : s0);
    tick(1'b1);
    chk_eq({tag, " R4 min written big"}, cur_big(), (b0 < b1) ? b0 : b1);
    chk_eq({tag, " R4 min written small"}, cur_sm(), (s0 < s1) ? s0 : s1);
  endtask

  task automatic run_sort(input string tag, input int pause_pct);
    for (int k = 0; k < D_BIG; k++) got_big[k] = 32'h7fff_ffff;
    for (int k = 0; k < D_SM; k++) got_sm[k] = 32'h7fff_ffff;
    first_steps(tag);
    while (!(fin_b && pf_b >= 4 && fin_s && pf_s >= 4 && e_cnt > F_BIG + 1))
      tick(($urandom % 100) >= pause_pct);
    for (int k = 0; k < D_BIG; k++)
      chk_eq({tag, " R7 R8 sorted entry big"}, got_big[k], sorted_at(D_BIG, S_BIG, k));
    for (int k = 0; k < D_SM; k++)
      chk_eq({tag, " R7 R8 sorted entry small"}, got_sm[k], sorted_at(D_SM, S_SM, k));
    for (int k = 1; k < D_BIG; k++)
      chk_eq({tag, " R8 non-decreasing big"}, int'(got_big[k - 1] <= got_big[k]), 1);
    repeat (20) tick(1'b1);
    chk_eq({tag, " R3 done stays big"}, int'(done_big), 1);
    chk_eq({tag, " R7 last entry held big"}, cur_big(), sorted_at(D_BIG, S_BIG, D_BIG - 1));
  endtask

  initial begin
    void'($urandom(32'd4111));
    do_reset("R1");
    run_sort("run1", 30);
    do_reset("R1 R9 second start");
    repeat (400) tick(($urandom % 100) >= 20);
    do_reset("R9 mid-sort");
    run_sort("R9 rerun", 10);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", e_cnt, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule